// File: doc/BRIEF.md
# Command Queue Trigger Mode Controller

This block decides when one command FIFO may push command messages towards a converter's command buffer. Software programs a trigger mode (off, single pass started by software, or single pass started by an edge of a trigger line) and can arm a single-pass flag. The controller tracks whether the queue is idle or executing, counts completed transfers, and watches the trigger input for edges. It issues a start strobe for each command that heads the FIFO and waits for the on-chip buffer write or the external serial shift to finish. The FIFO storage, the serial shifter and the fill-request engine are outside the block and appear only as handshake signals.

Turning the mode off is allowed at any moment. The fall back to idle then depends on what is in flight. An on-chip write always runs to completion and is counted. An external serial message is aborted unless its cut-off bit has already left the shifter, in which case it also completes and is counted. A single pass ends by itself once the end-of-queue command has been transferred.

Top module: `cmdq_trigger_ctrl`

## Requirements
- R1: After reset the mode reads 000, the queue is idle, the single-pass flag is 0 and the transfer count is 0.
- R2: A configuration write whose mode code is 000 or any of 101, 110, 111 sets the mode to 000 (off) from any mode in the next cycle. While the mode is off, neither the trigger line nor the enable bit starts execution.
- R3: A write of a non-off code that differs from a non-off current mode is ignored. A write that leaves off is accepted only while the queue is idle. Codes: 001 software single pass, 010 rising edge, 011 falling edge, 100 either edge.
- R4: A write that makes the mode 001 with the enable bit set raises the single-pass flag in the same write. The queue starts executing on the following clock edge.
- R5: In the edge modes (flag armed) only a trigger transition seen after the mode was entered starts execution. A level already present when the mode is entered does not.
- R6: While executing, a non-empty FIFO produces a one-cycle start strobe. The count rises by one when the buffer write (on-chip) or the serial done (external) arrives. A completed end-of-queue command clears the flag and returns the queue to idle.
- R7: Turning the mode off while executing with no transfer in flight makes the queue idle at the clock edge of the write.
- R8: Turning the mode off during an on-chip transfer keeps the queue active until the buffer write. That write is counted, and then the queue goes idle.
- R9: Turning the mode off during an external transfer with fewer than 26 bits shifted raises the abort strobe. The queue goes idle at that edge and the count is unchanged.
- R10: Turning the mode off during an external transfer with 26 or more bits shifted does not abort. The queue stays active until serial done, that transfer is counted, and then the queue goes idle.
- R11: Turning the mode off clears the single-pass flag but leaves the count unchanged. Only the count-clear strobe sets the count to 0.
- R12: An invalidate request is passed to the FIFO only while the queue is idle.
- R13: The fill request equals the fill enable while the FIFO is not full, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgMode | input | 3 | Mode code carried by the write |
| cfgSse | input | 1 | Single-pass enable bit carried by the write |
| tcClr | input | 1 | Clears the transfer count |
| invReq | input | 1 | FIFO invalidate request |
| trigIn | input | 1 | Synchronous trigger line |
| fifoNotEmpty | input | 1 | FIFO holds a command |
| cmdEoq | input | 1 | Head command ends the queue |
| cmdExt | input | 1 | Head command targets the external serial buffer |
| bufWrDone | input | 1 | On-chip buffer write finished |
| serDone | input | 1 | Serial message finished |
| serBitCnt | input | 6 | Bits of the current serial message already shifted |
| fillEn | input | 1 | Fill-request enable |
| fifoFull | input | 1 | FIFO full |
| modeOut | output | 3 | Current mode code |
| running | output | 1 | Queue executing (not idle) |
| sssFlag | output | 1 | Single-pass flag |
| tcCount | output | 8 | Completed transfer count |
| xferStart | output | 1 | Start strobe for the head command |
| xferAbort | output | 1 | Abort strobe to the serial shifter |
| fifoInval | output | 1 | Invalidate passed to the FIFO |
| fillReq | output | 1 | Fill request |

## Verification
The hardest case to reach is a mode-off write that lands exactly while a transfer is in flight, on either side of the serial cut-off bit. The directed tasks first start a pass and then hold the FIFO non-empty for one cycle so that one transfer is launched. They then write mode 000 in a cycle where the transfer state is known, with the shifted-bit count forced below or at the cut-off. The abort strobe is sampled before that clock edge, and the status and count are checked after it. During the on-chip case a further write tries to leave off while the queue is still active, which checks that the idle condition guards that write.

// File: rtl/cmdq_trig_pkg.sv
package cmdq_trig_pkg;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'b000,
    MODE_SW   = 3'b001,
    MODE_RISE = 3'b010,
    MODE_FALL = 3'b011,
    MODE_BOTH = 3'b100
  } trigMode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READY,
    ST_XINT,
    ST_XEXT
  } execState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tcInc;     // one transfer completed
    logic passDone;  // end-of-queue transfer completed
  } ctrlStrobe_t;

  function automatic trigMode_e normMode(input logic [2:0] code);
    case (code)
      3'b001:  return MODE_SW;
      3'b010:  return MODE_RISE;
      3'b011:  return MODE_FALL;
      3'b100:  return MODE_BOTH;
      default: return MODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/cmdq_trig_dp.sv
module cmdq_trig_dp
  import cmdq_trig_pkg::*;
#(
  parameter int TC_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWr,
  input  logic [2:0]      cfgMode,
  input  logic            cfgSse,
  input  logic            tcClr,
  input  logic            trigIn,
  input  logic            execIdle,
  input  ctrlStrobe_t     strobes,
  output trigMode_e       modeQ,
  output logic            modeIsDis,
  output logic            disWrite,
  output logic            trigFire,
  output logic            sssQ,
  output logic [TC_W-1:0] tcCount
);

  trigMode_e newMode;
  logic      acceptEn;
  logic      sssSet;
  logic      trigValid;
  logic      trigPrev;
  logic      riseEv;
  logic      fallEv;
  logic      edgeHit;

  assign newMode   = normMode(cfgMode);
  assign modeIsDis = (modeQ == MODE_OFF);
  assign disWrite  = cfgWr && (newMode == MODE_OFF);
  assign acceptEn  = cfgWr && (newMode != MODE_OFF) &&
                     ((modeIsDis && execIdle) || (modeQ == newMode));
  assign sssSet    = acceptEn && cfgSse;

  always_ff @(posedge clk) begin
    if (!rstN)          modeQ <= MODE_OFF;
    else if (disWrite)  modeQ <= MODE_OFF;
    else if (acceptEn)  modeQ <= newMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 sssQ <= 1'b0;
    else if (disWrite)         sssQ <= 1'b0;
    else if (sssSet)           sssQ <= 1'b1;
    else if (strobes.passDone) sssQ <= 1'b0;
  end

  // edge history is discarded while off: first sample after entry only primes
  always_ff @(posedge clk) begin
    if (!rstN || modeIsDis) begin
      trigValid <= 1'b0;
      trigPrev  <= 1'b0;
    end else begin
      trigValid <= 1'b1;
      trigPrev  <= trigIn;
    end
  end

  assign riseEv = trigValid && trigIn && !trigPrev;
  assign fallEv = trigValid && !trigIn && trigPrev;

  always_comb begin
    case (modeQ)
      MODE_SW:   edgeHit = 1'b1;
      MODE_RISE: edgeHit = riseEv;
      MODE_FALL: edgeHit = fallEv;
      MODE_BOTH: edgeHit = riseEv || fallEv;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign trigFire = !modeIsDis && !disWrite && sssQ && edgeHit;

  always_ff @(posedge clk) begin
    if (!rstN || tcClr)     tcCount <= '0;
    else if (strobes.tcInc) tcCount <= tcCount + 1'b1;
  end

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_OFF && $past(modeQ) != MODE_OFF) |-> modeQ == $past(modeQ));

  // R11
  sss_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_OFF) |-> !sssQ);

  // R11
  tc_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(tcClr) && !$past(strobes.tcInc)) |-> tcCount == $past(tcCount));

endmodule

// File: rtl/cmdq_trig_ctrl.sv
module cmdq_trig_ctrl
  import cmdq_trig_pkg::*;
#(
  parameter int BIT_W     = 6,
  parameter int ABORT_BIT = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeIsDis,
  input  logic             disWrite,
  input  logic             trigFire,
  input  logic             fifoNotEmpty,
  input  logic             cmdEoq,
  input  logic             cmdExt,
  input  logic             bufWrDone,
  input  logic             serDone,
  input  logic [BIT_W-1:0] serBitCnt,
  input  logic             invReq,
  output logic             running,
  output logic             execIdle,
  output logic             xferStart,
  output logic             xferAbort,
  output logic             fifoInval,
  output ctrlStrobe_t      strobes
);

  localparam logic [BIT_W-1:0] ABORT_LIM = BIT_W'(ABORT_BIT);

  execState_e state;
  execState_e stateNxt;
  logic       eoqQ;
  logic       stopReq;
  logic       canAbort;
  logic       doneNow;

  assign stopReq  = modeIsDis || disWrite;
  assign canAbort = serBitCnt < ABORT_LIM;

  assign xferStart = (state == ST_READY) && !stopReq && fifoNotEmpty;
  assign xferAbort = (state == ST_XEXT) && stopReq && canAbort;
  assign doneNow   = ((state == ST_XINT) && bufWrDone) ||
                     ((state == ST_XEXT) && serDone && !xferAbort);

  assign strobes.tcInc    = doneNow;
  assign strobes.passDone = doneNow && eoqQ;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  if (trigFire) stateNxt = ST_READY;
      ST_READY: begin
        if (stopReq)        stateNxt = ST_IDLE;
        else if (xferStart) stateNxt = cmdExt ? ST_XEXT : ST_XINT;
      end
      ST_XINT, ST_XEXT: begin
        if (xferAbort)    stateNxt = ST_IDLE;
        else if (doneNow) stateNxt = (stopReq || eoqQ) ? ST_IDLE : ST_READY;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      eoqQ  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (xferStart) eoqQ <= cmdEoq;
    end
  end

  assign running   = (state != ST_IDLE);
  assign execIdle  = (state == ST_IDLE);
  assign fifoInval = invReq && execIdle;

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferAbort |=> !running);

  // R8
  int_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XINT && !bufWrDone) |=> state == ST_XINT);

  // R10
  ext_late_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XEXT && !serDone && !canAbort) |=> state == ST_XEXT);

  // R6
  start_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> (state == ST_XINT || state == ST_XEXT));

endmodule

// File: rtl/cmdq_trigger_ctrl.sv
module cmdq_trigger_ctrl
  import cmdq_trig_pkg::*;
#(
  parameter int TC_W      = 8,
  parameter int BIT_W     = 6,
  parameter int ABORT_BIT = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [2:0]       cfgMode,
  input  logic             cfgSse,
  input  logic             tcClr,
  input  logic             invReq,
  input  logic             trigIn,
  input  logic             fifoNotEmpty,
  input  logic             cmdEoq,
  input  logic             cmdExt,
  input  logic             bufWrDone,
  input  logic             serDone,
  input  logic [BIT_W-1:0] serBitCnt,
  input  logic             fillEn,
  input  logic             fifoFull,
  output logic [2:0]       modeOut,
  output logic             running,
  output logic             sssFlag,
  output logic [TC_W-1:0]  tcCount,
  output logic             xferStart,
  output logic             xferAbort,
  output logic             fifoInval,
  output logic             fillReq
);

  trigMode_e   modeQ;
  logic        modeIsDis;
  logic        disWrite;
  logic        trigFire;
  logic        execIdle;
  ctrlStrobe_t strobes;

  cmdq_trig_dp #(.TC_W(TC_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .cfgMode   (cfgMode),
    .cfgSse    (cfgSse),
    .tcClr     (tcClr),
    .trigIn    (trigIn),
    .execIdle  (execIdle),
    .strobes   (strobes),
    .modeQ     (modeQ),
    .modeIsDis (modeIsDis),
    .disWrite  (disWrite),
    .trigFire  (trigFire),
    .sssQ      (sssFlag),
    .tcCount   (tcCount)
  );

  cmdq_trig_ctrl #(.BIT_W(BIT_W), .ABORT_BIT(ABORT_BIT)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .modeIsDis    (modeIsDis),
    .disWrite     (disWrite),
    .trigFire     (trigFire),
    .fifoNotEmpty (fifoNotEmpty),
    .cmdEoq       (cmdEoq),
    .cmdExt       (cmdExt),
    .bufWrDone    (bufWrDone),
    .serDone      (serDone),
    .serBitCnt    (serBitCnt),
    .invReq       (invReq),
    .running      (running),
    .execIdle     (execIdle),
    .xferStart    (xferStart),
    .xferAbort    (xferAbort),
    .fifoInval    (fifoInval),
    .strobes      (strobes)
  );

  assign modeOut = modeQ;
  // fill requests are independent of mode and execution state
  assign fillReq = fillEn && !fifoFull;

endmodule

// File: tb/cmdq_trigger_ctrl_tb.sv
module cmdq_trigger_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic [2:0] cfgMode = 3'b000;
  logic       cfgSse = 1'b0;
  logic       tcClr = 1'b0;
  logic       invReq = 1'b0;
  logic       trigIn = 1'b0;
  logic       fifoNotEmpty = 1'b0;
  logic       cmdEoq = 1'b0;
  logic       cmdExt = 1'b0;
  logic       bufWrDone = 1'b0;
  logic       serDone = 1'b0;
  logic [5:0] serBitCnt = 6'd0;
  logic       fillEn = 1'b0;
  logic       fifoFull = 1'b0;
  logic [2:0] modeOut;
  logic       running;
  logic       sssFlag;
  logic [7:0] tcCount;
  logic       xferStart;
  logic       xferAbort;
  logic       fifoInval;
  logic       fillReq;

  int testsRun = 0;
  int testsFailed = 0;
  int expTc = 0;

  always #2 clk = ~clk;

  cmdq_trigger_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgSse(cfgSse),
    .tcClr(tcClr), .invReq(invReq), .trigIn(trigIn), .fifoNotEmpty(fifoNotEmpty),
    .cmdEoq(cmdEoq), .cmdExt(cmdExt), .bufWrDone(bufWrDone), .serDone(serDone),
    .serBitCnt(serBitCnt), .fillEn(fillEn), .fifoFull(fifoFull), .modeOut(modeOut),
    .running(running), .sssFlag(sssFlag), .tcCount(tcCount), .xferStart(xferStart),
    .xferAbort(xferAbort), .fifoInval(fifoInval), .fillReq(fillReq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] code, input logic sse);
    cfgWr = 1'b1; cfgMode = code; cfgSse = sse;
    tick();
    cfgWr = 1'b0; cfgSse = 1'b0;
  endtask

  // arm software single pass and reach the executing state
  task automatic startSw();
    cfgWrite(3'b001, 1'b1);
    tick();
  endtask

  task automatic launch(input logic ext, input logic eoq);
    fifoNotEmpty = 1'b1; cmdExt = ext; cmdEoq = eoq;
    #1;
    check("R6", "start strobe", xferStart, 1);
    tick();
    fifoNotEmpty = 1'b0;
    #1;
    check("R6", "single start", xferStart, 0);
  endtask

  task automatic testReset();
    check("R1", "mode", modeOut, 0);
    check("R1", "running", running, 0);
    check("R1", "flag", sssFlag, 0);
    check("R1", "count", tcCount, 0);
  endtask

  task automatic testFill();
    fillEn = 1'b1; fifoFull = 1'b0; #1;
    check("R13", "fill req off-mode", fillReq, 1);
    fifoFull = 1'b1; #1;
    check("R13", "fill req full", fillReq, 0);
    fifoFull = 1'b0;
  endtask

  task automatic testSwPass();
    cfgWrite(3'b001, 1'b1);
    check("R4", "mode sw", modeOut, 1);
    check("R4", "flag set", sssFlag, 1);
    check("R4", "idle before trigger", running, 0);
    tick();
    check("R4", "running", running, 1);
    launch(1'b0, 1'b0);
    bufWrDone = 1'b1; tick(); bufWrDone = 1'b0; expTc++;
    check("R6", "count after write", tcCount, expTc);
    check("R6", "still running", running, 1);
    check("R13", "fill req while running", fillReq, 1);
    launch(1'b0, 1'b1);
    bufWrDone = 1'b1; tick(); bufWrDone = 1'b0; expTc++;
    check("R6", "count after eoq", tcCount, expTc);
    check("R6", "flag cleared by eoq", sssFlag, 0);
    check("R6", "idle after eoq", running, 0);
    tick();
    check("R6", "no restart", running, 0);
  endtask

  task automatic testModeRules();
    cfgWrite(3'b010, 1'b0);
    check("R3", "non-off change ignored", modeOut, 1);
    cfgWrite(3'b000, 1'b0);
    check("R2", "off accepted", modeOut, 0);
    cfgWrite(3'b011, 1'b0);
    check("R3", "leave off when idle", modeOut, 3);
    cfgWrite(3'b111, 1'b1);
    check("R2", "reserved code is off", modeOut, 0);
    check("R2", "flag stays clear", sssFlag, 0);
    trigIn = 1'b1; tick(); trigIn = 1'b0; tick();
    check("R2", "no trigger while off", running, 0);
  endtask

  task automatic testEdges();
    trigIn = 1'b1;
    cfgWrite(3'b010, 1'b1);
    tick(); tick(); tick();
    check("R5", "held level ignored", running, 0);
    trigIn = 1'b0; tick();
    check("R5", "falling ignored in rise mode", running, 0);
    trigIn = 1'b1; tick();
    check("R5", "rising edge starts", running, 1);
    cfgWrite(3'b000, 1'b0);
    check("R7", "idle at once", running, 0);
    check("R11", "flag cleared by off", sssFlag, 0);
    cfgWrite(3'b011, 1'b1);
    tick(); tick();
    check("R5", "fall mode waits", running, 0);
    trigIn = 1'b0; tick();
    check("R5", "falling edge starts", running, 1);
    cfgWrite(3'b000, 1'b0);
    cfgWrite(3'b100, 1'b1);
    tick(); tick();
    check("R5", "both mode waits", running, 0);
    trigIn = 1'b1; tick();
    check("R5", "either edge starts", running, 1);
    cfgWrite(3'b000, 1'b0);
    trigIn = 1'b0;
  endtask

  task automatic testOffOnChip();
    startSw();
    launch(1'b0, 1'b0);
    cfgWrite(3'b000, 1'b0);
    check("R8", "active during write", running, 1);
    check("R11", "flag cleared", sssFlag, 0);
    cfgWrite(3'b001, 1'b1);
    check("R3", "leave off refused while active", modeOut, 0);
    bufWrDone = 1'b1; tick(); bufWrDone = 1'b0; expTc++;
    check("R8", "write counted", tcCount, expTc);
    check("R8", "idle after write", running, 0);
  endtask

  task automatic testOffExtEarly();
    startSw();
    launch(1'b1, 1'b0);
    serBitCnt = 6'd25;
    cfgWr = 1'b1; cfgMode = 3'b000; #1;
    check("R9", "abort strobe", xferAbort, 1);
    tick(); cfgWr = 1'b0;
    check("R9", "idle after abort", running, 0);
    check("R9", "count unchanged", tcCount, expTc);
    serBitCnt = 6'd0;
  endtask

  task automatic testOffExtLate();
    startSw();
    launch(1'b1, 1'b0);
    serBitCnt = 6'd26;
    cfgWr = 1'b1; cfgMode = 3'b000; #1;
    check("R10", "no abort", xferAbort, 0);
    tick(); cfgWr = 1'b0;
    check("R10", "still active", running, 1);
    serDone = 1'b1; tick(); serDone = 1'b0; expTc++;
    check("R10", "serial counted", tcCount, expTc);
    check("R10", "idle after done", running, 0);
    serBitCnt = 6'd0;
  endtask

  task automatic testInvalClear();
    startSw();
    invReq = 1'b1; #1;
    check("R12", "inval blocked while active", fifoInval, 0);
    cfgWrite(3'b000, 1'b0);
    check("R11", "count kept on off", tcCount, expTc);
    #1;
    check("R12", "inval passed when idle", fifoInval, 1);
    invReq = 1'b0;
    tcClr = 1'b1; tick(); tcClr = 1'b0; expTc = 0;
    check("R11", "count cleared", tcCount, 0);
  endtask

  initial begin
    #(200000 * 4);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    testReset();
    testFill();
    testSwPass();
    testModeRules();
    testEdges();
    testOffOnChip();
    testOffExtEarly();
    testOffExtLate();
    testInvalClear();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule